// File: doc/BRIEF.md
# Vault Atomic Memory Unit

This block is the execution unit that sits beside a memory vault's controller and carries out indivisible read-modify-write operations for any core that sends it a request. The address in a request has already been routed to this vault by the network. The unit reads the addressed word, applies the operation, writes the result back and returns the word's prior value to the requester. The supported operations are fetch-and-add and compare-and-swap, together with plain reads and writes. From these, software can build spin locks, counters and tree-style barriers.

The storage is modelled as a word array with a fixed read latency. Requests to different words flow through a pipeline at one per cycle. A request whose word still has an operation in flight is refused with `req_ready` low until that operation has written its result, so every operation on one word is seen as indivisible and in arrival order. A request from a core in the same stack and one from another stack use the same port and the same semantics. The requester identity travels only inside the opaque tag, which comes back unchanged.

Top module: `vamu_top`

## Requirements
- R1: A fetch-and-add (`req_op` = 2) returns the word's prior value and stores prior + `req_opnd`, wrapping modulo 2^DATA_W.
- R2: A compare-and-swap (`req_op` = 3) stores `req_opnd` only when the stored word equals `req_cmp`, leaves the word unchanged otherwise, and always returns the prior value.
- R3: `rsp_ok` is 1 exactly for a compare-and-swap that stored its new value; it is 0 for a failed compare-and-swap and for every other operation.
- R4: A read (`req_op` = 0) returns the word and leaves it unchanged; a write (`req_op` = 1) stores `req_opnd` and its response carries the prior value.
- R5: While a request to a word is in flight, a new request to the same word sees `req_ready` low; it is accepted only after the earlier write is done, so same-word accepts are at least LAT+1 cycles apart and at most one operation per word is in flight.
- R6: Requests to different words are accepted on consecutive cycles with no stall.
- R7: Each response appears exactly LAT cycles after its request was accepted and carries the request's `req_tag` unchanged; the tag value, including the bit that marks a local or remote requester, has no effect on the result.
- R8: After reset every word reads 0, `rsp_valid` is 0 and `req_ready` is 1.
- R9: A plain write that arrives while an atomic to the same word is in flight takes effect after that atomic, so a later read returns the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_op | input | 2 | 0 read, 1 write, 2 fetch-and-add, 3 compare-and-swap |
| req_addr | input | ADDR_W | Word index inside this vault |
| req_opnd | input | DATA_W | Write data, addend, or compare-and-swap new value |
| req_cmp | input | DATA_W | Compare-and-swap expected value |
| req_tag | input | TAG_W | Requester transaction tag, returned unchanged |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_tag | output | TAG_W | Tag of the finished request |
| rsp_data | output | DATA_W | Word value before the operation |
| rsp_ok | output | 1 | Compare-and-swap stored its new value |

## Verification
Every response is due exactly LAT cycles after the clock edge that accepted its request. A request refused behind a same-word operation can be accepted no earlier than LAT+1 cycles after that operation. The driver stamps each accepted request with the cycle on which its answer must arrive, and pushes the predicted value, tag and flag into a queue. The monitor compares each response against the head of that queue, including the arrival cycle. Accept-to-accept spacing is measured separately for same-word and different-word sequences.

// File: rtl/vamu_pkg.sv
package vamu_pkg;
   typedef enum logic [1:0] {
      OP_RD   = 2'd0,
      OP_WR   = 2'd1,
      OP_FADD = 2'd2,
      OP_CAS  = 2'd3
   } vamu_op_e;
endpackage

// File: rtl/vamu_store.sv
module vamu_store #(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_depth
      $error("vamu_store: ADDR_W out of range");
   end

   logic [DATA_W-1:0] words [DEPTH];

   assign rd_data = words[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) words[i] <= '0;
      end else if (wr_en) begin
         words[wr_addr] <= wr_data;
      end
   end

   // R4: the written word is visible to the read port on the next cycle
   p_store_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_addr == wr_addr) |=> ($stable(rd_addr) -> rd_data == $past(wr_data)));
endmodule

// File: rtl/vamu_hazard.sv
module vamu_hazard #(
   parameter int ADDR_W = 6,
   parameter int STAGES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAGES-1:0] st_valid,
   input  logic [ADDR_W-1:0] st_addr [STAGES],
   input  logic [ADDR_W-1:0] probe_addr,
   output logic              busy
);
   logic [STAGES-1:0] match;

   for (genvar s = 0; s < STAGES; s++) begin : g_cmp
      assign match[s] = st_valid[s] && (st_addr[s] == probe_addr);
   end

   assign busy = |match;

   // R5: never more than one operation in flight on the same word
   p_single_inflight_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));
endmodule

// File: rtl/vamu_alu.sv
module vamu_alu
   import vamu_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  vamu_op_e          op,
   input  logic [DATA_W-1:0] old_val,
   input  logic [DATA_W-1:0] opnd,
   input  logic [DATA_W-1:0] cmp,
   output logic [DATA_W-1:0] new_val,
   output logic              wr_en,
   output logic              cas_ok
);
   always_comb begin
      new_val = old_val;
      wr_en   = 1'b0;
      cas_ok  = 1'b0;
      unique case (op)
         OP_RD: ;
         OP_WR: begin
            new_val = opnd;
            wr_en   = 1'b1;
         end
         OP_FADD: begin
            new_val = old_val + opnd;
            wr_en   = 1'b1;
         end
         OP_CAS: begin
            cas_ok  = (old_val == cmp);
            wr_en   = cas_ok;
            new_val = opnd;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/vamu_top.sv
module vamu_top
   import vamu_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 6,
   parameter int TAG_W  = 8,
   parameter int LAT    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_opnd,
   input  logic [DATA_W-1:0] req_cmp,
   input  logic [TAG_W-1:0]  req_tag,
   output logic              rsp_valid,
   output logic [TAG_W-1:0]  rsp_tag,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_ok
);
   localparam int LAST = LAT - 1;

   if (LAT < 1 || LAT > 16) begin : g_bad_lat
      $error("vamu_top: LAT must be 1..16");
   end
   if (DATA_W < 8) begin : g_bad_width
      $error("vamu_top: DATA_W too small");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("vamu_top: TAG_W must be positive");
   end

   logic [LAT-1:0]    st_v;
   vamu_op_e          st_op   [LAT];
   logic [ADDR_W-1:0] st_a    [LAT];
   logic [DATA_W-1:0] st_old  [LAT];
   logic [DATA_W-1:0] st_opnd [LAT];
   logic [DATA_W-1:0] st_cmp  [LAT];
   logic [TAG_W-1:0]  st_tag  [LAT];

   logic              busy;
   logic              accept;
   logic [DATA_W-1:0] rd_data;
   logic [DATA_W-1:0] fin_new;
   logic              fin_we;
   logic              fin_ok;

   vamu_hazard #(.ADDR_W(ADDR_W), .STAGES(LAT)) u_hazard (
      .clk        (clk),
      .rst_n      (rst_n),
      .st_valid   (st_v),
      .st_addr    (st_a),
      .probe_addr (req_addr),
      .busy       (busy)
   );

   assign req_ready = !busy;
   assign accept    = req_valid && req_ready;

   vamu_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_addr (req_addr),
      .rd_data (rd_data),
      .wr_en   (st_v[LAST] && fin_we),
      .wr_addr (st_a[LAST]),
      .wr_data (fin_new)
   );

   vamu_alu #(.DATA_W(DATA_W)) u_alu (
      .op      (st_op[LAST]),
      .old_val (st_old[LAST]),
      .opnd    (st_opnd[LAST]),
      .cmp     (st_cmp[LAST]),
      .new_val (fin_new),
      .wr_en   (fin_we),
      .cas_ok  (fin_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LAT; i++) begin
            st_v[i]    <= 1'b0;
            st_op[i]   <= OP_RD;
            st_a[i]    <= '0;
            st_old[i]  <= '0;
            st_opnd[i] <= '0;
            st_cmp[i]  <= '0;
            st_tag[i]  <= '0;
         end
      end else begin
         st_v[0]    <= accept;
         st_op[0]   <= vamu_op_e'(req_op);
         st_a[0]    <= req_addr;
         st_old[0]  <= rd_data;
         st_opnd[0] <= req_opnd;
         st_cmp[0]  <= req_cmp;
         st_tag[0]  <= req_tag;
         for (int i = 1; i < LAT; i++) begin
            st_v[i]    <= st_v[i-1];
            st_op[i]   <= st_op[i-1];
            st_a[i]    <= st_a[i-1];
            st_old[i]  <= st_old[i-1];
            st_opnd[i] <= st_opnd[i-1];
            st_cmp[i]  <= st_cmp[i-1];
            st_tag[i]  <= st_tag[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_tag   <= '0;
         rsp_data  <= '0;
         rsp_ok    <= 1'b0;
      end else begin
         rsp_valid <= st_v[LAST];
         rsp_tag   <= st_tag[LAST];
         rsp_data  <= st_old[LAST];
         rsp_ok    <= st_v[LAST] && fin_ok;
      end
   end

   // R1: a finishing fetch-and-add answers with the word value it read
   p_fadd_old_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_v[LAST] && st_op[LAST] == OP_FADD) |=> (rsp_valid && rsp_data == $past(st_old[LAST])));

   // R2: a mismatching compare-and-swap reports no store
   p_cas_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_v[LAST] && st_op[LAST] == OP_CAS && st_old[LAST] != st_cmp[LAST]) |=> !rsp_ok);

   // R3: only compare-and-swap can raise the success flag
   p_ok_only_cas_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_v[LAST] && st_op[LAST] != OP_CAS) |=> !rsp_ok);

   // R7: the response tag is the tag carried down the pipeline
   p_tag_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      st_v[LAST] |=> (rsp_valid && rsp_tag == $past(st_tag[LAST])));

   // R7: no response without a finishing request
   p_rsp_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(st_v[LAST]));
endmodule

// File: tb/vamu_top_test.sv
`timescale 1ns/100ps
module vamu_top_test;
   localparam int DW  = 64;
   localparam int AW  = 6;
   localparam int TW  = 8;
   localparam int LAT = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_opnd = '0;
   logic [DW-1:0] req_cmp = '0;
   logic [TW-1:0] req_tag = '0;
   logic          rsp_valid;
   logic [TW-1:0] rsp_tag;
   logic [DW-1:0] rsp_data;
   logic          rsp_ok;

   always #2.5 clk = ~clk;

   vamu_top #(.DATA_W(DW), .ADDR_W(AW), .TAG_W(TW), .LAT(LAT)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_addr(req_addr), .req_opnd(req_opnd), .req_cmp(req_cmp), .req_tag(req_tag),
      .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data), .rsp_ok(rsp_ok)
   );

   typedef struct {
      logic [TW-1:0] tag;
      logic [DW-1:0] data;
      logic          ok;
      int            due;
      string         rq;
   } exp_t;

   exp_t          sb[$];
   logic [DW-1:0] model [1 << AW];
   int            cyc = 0;
   int            total = 0;
   int            bad = 0;
   int            last_acc = 0;
   bit            finished = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit cond, input string rq, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (!cond) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] opnd, input logic [DW-1:0] cmp,
                        input logic [TW-1:0] tag, input string rq);
      exp_t e;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = a;
      req_opnd = opnd; req_cmp = cmp; req_tag = tag;
      #1;
      while (!req_ready) begin
         @(negedge clk);
         #1;
      end
      e.tag = tag;
      e.data = model[a];
      e.ok = 1'b0;
      e.due = cyc + 1 + LAT;
      e.rq = rq;
      case (op)
         2'd1: model[a] = opnd;
         2'd2: model[a] = model[a] + opnd;
         2'd3: if (model[a] == cmp) begin
            model[a] = opnd;
            e.ok = 1'b1;
         end
         default: ;
      endcase
      sb.push_back(e);
      last_acc = cyc + 1;
      @(posedge clk);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic drain();
      idle();
      repeat (LAT + 3) @(negedge clk);
   endtask

   // monitor: compare each response with the scoreboard head
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R7", "unexpected response", {{(DW-TW){1'b0}}, rsp_tag}, '0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(rsp_data == e.data, e.rq, "data", rsp_data, e.data);
            check(rsp_tag == e.tag, e.rq, "tag", {{(DW-TW){1'b0}}, rsp_tag}, {{(DW-TW){1'b0}}, e.tag});
            check(rsp_ok == e.ok, e.rq, "ok flag", {{(DW-1){1'b0}}, rsp_ok}, {{(DW-1){1'b0}}, e.ok});
            check(cyc == e.due, e.rq, "arrival cycle", cyc, e.due);
         end
      end
   end

   initial begin
      #200000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int a0;
      for (int i = 0; i < (1 << AW); i++) model[i] = '0;
      repeat (3) @(negedge clk);
      // R8: reset state
      check(rsp_valid == 1'b0, "R8", "rsp_valid after reset", rsp_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check(req_ready == 1'b1, "R8", "req_ready after reset", req_ready, 1);
      check(rsp_valid == 1'b0, "R8", "rsp_valid idle", rsp_valid, 0);
      issue(2'd0, 6'd3, '0, '0, 8'h01, "R8");
      issue(2'd0, 6'd63, '0, '0, 8'h02, "R8");
      drain();

      // R4: write then read
      issue(2'd1, 6'd10, 64'hDEAD_BEEF_0123_4567, '0, 8'h10, "R4");
      drain();
      issue(2'd0, 6'd10, '0, '0, 8'h11, "R4");
      issue(2'd0, 6'd10, '0, '0, 8'h12, "R4");
      drain();

      // R6: different words back to back
      issue(2'd1, 6'd1, 64'd11, '0, 8'h20, "R6");
      a0 = last_acc;
      issue(2'd1, 6'd2, 64'd22, '0, 8'h21, "R6");
      check(last_acc - a0 == 1, "R6", "accept spacing", last_acc - a0, 1);
      issue(2'd2, 6'd4, 64'd7, '0, 8'h22, "R6");
      drain();

      // R1 and R5: same-word fetch-and-add held
      issue(2'd2, 6'd5, 64'd100, '0, 8'h30, "R1");
      a0 = last_acc;
      issue(2'd2, 6'd5, 64'd23, '0, 8'h31, "R5");
      check(last_acc - a0 == LAT + 1, "R5", "same-word accept spacing", last_acc - a0, LAT + 1);
      issue(2'd0, 6'd5, '0, '0, 8'h32, "R1");
      drain();

      // R1: wrap-around
      issue(2'd1, 6'd40, {DW{1'b1}}, '0, 8'h40, "R1");
      issue(2'd2, 6'd40, 64'd2, '0, 8'h41, "R1");
      issue(2'd0, 6'd40, '0, '0, 8'h42, "R1");
      drain();

      // R2 and R3: lock via compare-and-swap
      issue(2'd3, 6'd30, 64'd1, 64'd0, 8'h50, "R2");
      issue(2'd3, 6'd30, 64'd1, 64'd0, 8'h51, "R3");
      issue(2'd0, 6'd30, '0, '0, 8'h52, "R2");
      issue(2'd1, 6'd30, 64'd0, '0, 8'h53, "R3");
      issue(2'd3, 6'd30, 64'd9, 64'd0, 8'h54, "R2");
      issue(2'd0, 6'd30, '0, '0, 8'h55, "R2");
      drain();

      // R9: write behind in-flight atomic
      issue(2'd2, 6'd9, 64'd5, '0, 8'h60, "R9");
      issue(2'd1, 6'd9, 64'd100, '0, 8'h61, "R9");
      issue(2'd0, 6'd9, '0, '0, 8'h62, "R9");
      drain();

      // R7: counter from local (bit7=0) and remote (bit7=1) requesters
      for (int k = 0; k < 10; k++)
         issue(2'd2, 6'd20, 64'd1, '0, (k % 2 == 1) ? 8'(8'h80 | k) : 8'(k), "R7");
      issue(2'd0, 6'd20, '0, '0, 8'hF0, "R7");
      // interleaved words keep full rate with mixed tags
      for (int k = 0; k < 8; k++)
         issue(2'd2, 6'(48 + k), 64'(k + 1), '0, 8'(8'hA0 + k), "R6");
      drain();
      for (int k = 0; k < 8; k++)
         issue(2'd0, 6'(48 + k), '0, '0, 8'(8'hB0 + k), "R1");
      drain();

      check(sb.size() == 0, "R7", "responses outstanding", sb.size(), 0);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule